// File: doc/BRIEF.md
# Synchronous Rectifier Gate-Enable Logic

This block is the clocked decision logic that sits between a PWM controller and the gate driver of a synchronous-rectifier switch. It takes four inputs: the controller's gate command, a digitized flag from the body-diode conduction comparator, a select that enables turn-on optimization, and a supply-good flag. From these it produces a gate-enable output and an active-low conduction report that goes back to the controller. The controller uses that report to tune its dead time.

All four inputs pass through a synchronizer with `SYNC_STAGES` flops. The outputs are registered after that. With the default of two stages, a change on any input reaches the outputs on the third rising clock edge after it is applied.

With optimization enabled, a command rising edge does not always turn the gate on straight away. The gate turns on at once only if diode conduction is already present. Otherwise the block waits for conduction to appear. A command falling edge always turns the gate off, whatever the conduction flag shows. While the gate is on, the conduction report is blanked. While the supply is in lockout, the gate is held off and no conduction is reported.

Top module: `sr_gate_enable`

## Requirements
- R1: A synchronous active-high `rst` sets `gateEn` to 0 and `condRptN` to 1 at the next rising edge. It also clears the synchronizers and returns the control to idle.
- R2: `gateEn` is 1 only if the synchronized command was 1 in the cycle before. This holds in every state and in both modes.
- R3: With `optEn`=1 and `supplyOk`=1, a rising edge on `pwmCmd` while `diodeOn`=1 raises `gateEn` on the third clock edge after the inputs change.
- R4: With `optEn`=1, a rising edge on `pwmCmd` while `diodeOn`=0 keeps `gateEn` at 0 for as long as `diodeOn` stays 0. When `diodeOn` first becomes 1 while the command is still high, `gateEn` rises three edges later.
- R5: A falling edge on `pwmCmd` drives `gateEn` to 0 three edges later, whatever the value of `diodeOn`.
- R6: `condRptN` is active-low. It is 0 when the synchronized `diodeOn` is 1, the supply is good and the gate is not being driven. Otherwise it is 1.
- R7: Whenever `gateEn` is 1, `condRptN` is 1 (the report is blanked).
- R8: With `optEn`=0, `gateEn` follows the synchronized `pwmCmd` (gated by `supplyOk`) and ignores `diodeOn`.
- R9: While the synchronized `supplyOk` is 0, `gateEn` is 0 and `condRptN` is 1, whatever the other inputs are.
- R10: If the command falls while the block is waiting for conduction, the wait is abandoned. Conduction that appears after that does not raise `gateEn`.
- R11: With `optEn`=1, if the supply becomes good while the command is already high, `gateEn` stays 0 until the next command rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwmCmd | input | 1 | Gate command from the PWM controller |
| diodeOn | input | 1 | Comparator flag, 1 = body-diode conduction |
| optEn | input | 1 | 1 = turn-on optimization enabled, 0 = gate follows the command |
| supplyOk | input | 1 | 1 = supply above lockout threshold |
| gateEn | output | 1 | Gate-enable to the driver stage |
| condRptN | output | 1 | Conduction report, 0 = conduction sensed |

## Verification
Suppose the control state is wrong, for example stuck waiting or left on after the command dropped. `gateEn` then disagrees with the reference model within three clock edges of the stimulus that should have moved it, and an abandoned wait shows up as a gate pulse when late conduction arrives. A broken edge detector either turns the gate on when the supply recovers mid-pulse or never turns it on at all. A broken blanking or lockout term shows up on `condRptN` in the same cycle that `gateEn` or the supply flag changes.

// File: rtl/sr_gate_pkg.sv
package sr_gate_pkg;

  // Control states of the gate decision.
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_ON   = 2'd2
  } gate_state_e;

  // Strobes from the datapath to the control.
  typedef struct packed {
    logic cmdLevel;
    logic cmdRise;
    logic cmdFall;
    logic diode;
    logic supplyGood;
    logic optimize;
  } dp_status_t;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic driveGate;
    logic waiting;
  } ctrl_cmd_t;

  // Bit positions inside the synchronizer bus.
  localparam int BIT_CMD = 0;
  localparam int BIT_DIODE = 1;
  localparam int BIT_SUPPLY = 2;
  localparam int BIT_OPT = 3;
  localparam int IN_WIDTH = 4;

endpackage

// File: rtl/sr_gate_sync.sv
module sr_gate_sync #(
  parameter int WIDTH = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      logic [WIDTH-1:0] q;
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) q <= '0;
          else     q <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) q <= '0;
          else     q <= g_stage[g-1].q;
        end
      end
    end
  endgenerate

  assign dout = g_stage[STAGES-1].q;

endmodule

// File: rtl/sr_gate_dp.sv
module sr_gate_dp
  import sr_gate_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pwmCmd,
  input  logic       diodeOn,
  input  logic       optEn,
  input  logic       supplyOk,
  input  ctrl_cmd_t  ctrlCmd,
  output dp_status_t dpStatus,
  output logic       gateEn,
  output logic       condRptN
);

  logic [IN_WIDTH-1:0] rawBus;
  logic [IN_WIDTH-1:0] syncBus;
  logic cmdDly;
  logic reportLow;

  always_comb begin
    rawBus = '0;
    rawBus[BIT_CMD] = pwmCmd;
    rawBus[BIT_DIODE] = diodeOn;
    rawBus[BIT_SUPPLY] = supplyOk;
    rawBus[BIT_OPT] = optEn;
  end

  sr_gate_sync #(
    .WIDTH (IN_WIDTH),
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .din (rawBus),
    .dout(syncBus)
  );

  // Previous synchronized command for edge detection.
  always_ff @(posedge clk) begin
    if (rst) cmdDly <= 1'b0;
    else     cmdDly <= syncBus[BIT_CMD];
  end

  always_comb begin
    dpStatus.cmdLevel   = syncBus[BIT_CMD];
    dpStatus.cmdRise    = syncBus[BIT_CMD] & ~cmdDly;
    dpStatus.cmdFall    = ~syncBus[BIT_CMD] & cmdDly;
    dpStatus.diode      = syncBus[BIT_DIODE];
    dpStatus.supplyGood = syncBus[BIT_SUPPLY];
    dpStatus.optimize   = syncBus[BIT_OPT];
  end

  // The detector is inactive in lockout and its report is blanked while the gate is driven.
  assign reportLow = syncBus[BIT_DIODE] & syncBus[BIT_SUPPLY] & ~ctrlCmd.driveGate;

  always_ff @(posedge clk) begin
    if (rst) begin
      gateEn   <= 1'b0;
      condRptN <= 1'b1;
    end else begin
      gateEn   <= ctrlCmd.driveGate;
      condRptN <= ~reportLow;
    end
  end

endmodule

// File: rtl/sr_gate_ctrl.sv
module sr_gate_ctrl
  import sr_gate_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  dp_status_t dpStatus,
  output ctrl_cmd_t  ctrlCmd,
  output gate_state_e stateQ
);

  gate_state_e stateNext;

  always_comb begin
    stateNext = stateQ;
    if (!dpStatus.supplyGood || !dpStatus.cmdLevel) begin
      stateNext = ST_IDLE;
    end else begin
      unique case (stateQ)
        ST_IDLE: begin
          if (!dpStatus.optimize)    stateNext = ST_ON;
          else if (dpStatus.cmdRise) stateNext = dpStatus.diode ? ST_ON : ST_WAIT;
        end
        ST_WAIT: begin
          if (!dpStatus.optimize || dpStatus.diode) stateNext = ST_ON;
        end
        ST_ON:   stateNext = ST_ON;
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) stateQ <= ST_IDLE;
    else     stateQ <= stateNext;
  end

  always_comb begin
    ctrlCmd.driveGate = (stateNext == ST_ON);
    ctrlCmd.waiting   = (stateNext == ST_WAIT);
  end

endmodule

// File: rtl/sr_gate_enable.sv
module sr_gate_enable
  import sr_gate_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pwmCmd,
  input  logic diodeOn,
  input  logic optEn,
  input  logic supplyOk,
  output logic gateEn,
  output logic condRptN
);

  dp_status_t  dpStatus;
  ctrl_cmd_t   ctrlCmd;
  gate_state_e ctrlState;

  sr_gate_dp #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .pwmCmd  (pwmCmd),
    .diodeOn (diodeOn),
    .optEn   (optEn),
    .supplyOk(supplyOk),
    .ctrlCmd (ctrlCmd),
    .dpStatus(dpStatus),
    .gateEn  (gateEn),
    .condRptN(condRptN)
  );

  sr_gate_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .dpStatus(dpStatus),
    .ctrlCmd (ctrlCmd),
    .stateQ  (ctrlState)
  );

endmodule

// File: rtl/sr_gate_checker.sv
module sr_gate_checker (
  input logic clk,
  input logic rst,
  input logic gateEn,
  input logic condRptN,
  input logic cmdSync,
  input logic cmdFall,
  input logic supplySync,
  input logic waiting,
  input logic diodeSync
);

  assert_reset_outputs_R1: assert property (@(posedge clk)
    $past(rst) |-> (!gateEn && condRptN));

  assert_gate_needs_cmd_R2: assert property (@(posedge clk) disable iff (rst)
    gateEn |-> $past(cmdSync));

  assert_fall_turns_off_R5: assert property (@(posedge clk) disable iff (rst)
    $past(cmdFall) |-> !gateEn);

  assert_blank_report_R7: assert property (@(posedge clk) disable iff (rst)
    gateEn |-> condRptN);

  assert_lockout_safe_R9: assert property (@(posedge clk) disable iff (rst)
    !$past(supplySync) |-> (!gateEn && condRptN));

  // R4: a pending wait without conduction never drives the gate.
  assert_wait_holds_off_R4: assert property (@(posedge clk) disable iff (rst)
    ($past(waiting) && !$past(diodeSync)) |-> !gateEn);

endmodule

bind sr_gate_enable sr_gate_checker u_checker (
  .clk       (clk),
  .rst       (rst),
  .gateEn    (gateEn),
  .condRptN  (condRptN),
  .cmdSync   (dpStatus.cmdLevel),
  .cmdFall   (dpStatus.cmdFall),
  .supplySync(dpStatus.supplyGood),
  .waiting   (ctrlCmd.waiting),
  .diodeSync (dpStatus.diode)
);

// File: tb/sr_gate_enable_bench.sv
`timescale 1ns/1ps
module sr_gate_enable_bench;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwmCmd = 1'b0, diodeOn = 1'b0, optEn = 1'b1, supplyOk = 1'b0;
  logic gateEn, condRptN;

  int total = 0;
  int bad = 0;
  string curReq = "R1";
  bit finished = 0;

  always #4 clk = ~clk;

  sr_gate_enable u_sr_gate_enable (
    .clk(clk), .rst(rst), .pwmCmd(pwmCmd), .diodeOn(diodeOn),
    .optEn(optEn), .supplyOk(supplyOk), .gateEn(gateEn), .condRptN(condRptN)
  );

  // Reference model: input history queue plus a behavioural gate decision.
  bit histCmd[$], histDio[$], histOk[$], histOpt[$];
  bit prevCmd = 0;
  int mode = 0;          // 0 idle, 1 waiting, 2 driving
  bit expGate = 0, expRpt = 1;

  initial begin
    for (int i = 0; i < 2; i++) begin
      histCmd.push_back(0); histDio.push_back(0); histOk.push_back(0); histOpt.push_back(0);
    end
  end

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 2; i++) begin
        histCmd[i] = 0; histDio[i] = 0; histOk[i] = 0; histOpt[i] = 0;
      end
      prevCmd = 0; mode = 0; expGate = 0; expRpt = 1;
    end else begin
      bit c, d, ok, op;
      c = histCmd.pop_front(); d = histDio.pop_front();
      ok = histOk.pop_front(); op = histOpt.pop_front();
      if (!ok || !c) mode = 0;
      else if (mode == 0) begin
        if (!op) mode = 2;
        else if (c && !prevCmd) mode = d ? 2 : 1;
      end else if (mode == 1) begin
        if (!op || d) mode = 2;
      end
      expGate = (mode == 2);
      expRpt = !(d && ok && mode != 2);
      prevCmd = c;
      histCmd.push_back(pwmCmd); histDio.push_back(diodeOn);
      histOk.push_back(supplyOk); histOpt.push_back(optEn);
    end
  end

  // Per-cycle comparison away from the active edge.
  always @(negedge clk) begin
    if (!finished) begin
      total++;
      if (gateEn !== expGate || condRptN !== expRpt) begin
        bad++;
        $display("FAIL %s model: gate=%b rpt=%b expected gate=%b rpt=%b at %0t",
                 curReq, gateEn, condRptN, expGate, expRpt, $time);
      end
    end
  end

  task automatic waitCyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(logic act, logic exp, string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", what, act, exp);
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    waitCyc(3);
    chk(gateEn, 1'b0, "R1 gate in reset");
    chk(condRptN, 1'b1, "R1 report in reset");
    rst = 1'b0; supplyOk = 1'b1; optEn = 1'b1;
    waitCyc(4);

    curReq = "R3";
    diodeOn = 1'b1; pwmCmd = 1'b1;
    waitCyc(2);
    chk(gateEn, 1'b0, "R3 before latency");
    waitCyc(1);
    chk(gateEn, 1'b1, "R3 immediate turn-on");
    chk(condRptN, 1'b1, "R7 blanked while gate on");

    curReq = "R5";
    pwmCmd = 1'b0;
    waitCyc(3);
    chk(gateEn, 1'b0, "R5 off at fall with conduction");
    chk(condRptN, 1'b0, "R6 report low with conduction, gate off");
    diodeOn = 1'b0;
    waitCyc(4);
    chk(condRptN, 1'b1, "R6 report high without conduction");

    curReq = "R4";
    pwmCmd = 1'b1;
    waitCyc(8);
    chk(gateEn, 1'b0, "R4 deferred without conduction");
    diodeOn = 1'b1;
    waitCyc(3);
    chk(gateEn, 1'b1, "R4 on once conduction seen");
    curReq = "R5";
    pwmCmd = 1'b0; diodeOn = 1'b0;
    waitCyc(4);
    chk(gateEn, 1'b0, "R5 off at fall without conduction");

    curReq = "R10";
    pwmCmd = 1'b1;
    waitCyc(5);
    pwmCmd = 1'b0;
    waitCyc(4);
    diodeOn = 1'b1;
    waitCyc(5);
    chk(gateEn, 1'b0, "R10 abandoned wait stays off");
    chk(condRptN, 1'b0, "R10 report low after abandoned wait");
    diodeOn = 1'b0;
    waitCyc(4);

    curReq = "R8";
    optEn = 1'b0; pwmCmd = 1'b1;
    waitCyc(4);
    chk(gateEn, 1'b1, "R8 follows command with no conduction");
    pwmCmd = 1'b0;
    waitCyc(4);
    chk(gateEn, 1'b0, "R8 follows command low");

    curReq = "R9";
    optEn = 1'b1; diodeOn = 1'b1; pwmCmd = 1'b1;
    waitCyc(4);
    chk(gateEn, 1'b1, "R9 precondition gate on");
    supplyOk = 1'b0;
    waitCyc(4);
    chk(gateEn, 1'b0, "R9 lockout forces gate off");
    chk(condRptN, 1'b1, "R9 lockout suppresses report");

    curReq = "R11";
    supplyOk = 1'b1;
    waitCyc(6);
    chk(gateEn, 1'b0, "R11 recovery mid-pulse stays off");
    pwmCmd = 1'b0;
    waitCyc(4);
    pwmCmd = 1'b1;
    waitCyc(4);
    chk(gateEn, 1'b1, "R11 next rising edge turns on");
    pwmCmd = 1'b0;
    waitCyc(4);

    curReq = "R2";
    for (int i = 0; i < 3000; i++) begin
      pwmCmd = ($urandom_range(0, 3) != 0) ? ~pwmCmd : pwmCmd;
      diodeOn = $urandom_range(0, 1);
      if ($urandom_range(0, 40) == 0) supplyOk = ~supplyOk;
      if ($urandom_range(0, 60) == 0) optEn = ~optEn;
      @(negedge clk);
      if (gateEn) begin
        total++;
        if (condRptN !== 1'b1) begin
          bad++;
          $display("FAIL R7 random: actual=%b expected=1", condRptN);
        end
      end
    end

    curReq = "R1";
    pwmCmd = 1'b1; diodeOn = 1'b1; supplyOk = 1'b1; optEn = 1'b0;
    waitCyc(4);
    rst = 1'b1;
    waitCyc(1);
    chk(gateEn, 1'b0, "R1 mid-run reset gate");
    chk(condRptN, 1'b1, "R1 mid-run reset report");
    rst = 1'b0;
    waitCyc(5);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule